// File: doc/BRIEF.md
# Bitslip Word Boundary Aligner

This block sits directly behind a deserializer. It runs in the recovered receive clock domain and takes in one parallel word per cycle. It keeps the word from the previous cycle, which gives it a two-word window of the bit stream. The registered output word is cut from that window at a bit offset, so the word boundary can sit anywhere in the stream. Bit 0 of each input word is the earliest bit received.

Downstream framing logic moves the boundary by toggling a slip request line. That line is asynchronous to the receive clock. Inside the block it passes through a flop synchronizer and a rising-edge detector. Each detected edge moves the boundary one bit later in time, which drops the earliest pending bit. Slips are acted on only while the alignment-mode input is high.

The block presents the accumulated slip count so that latency accounting can include it. The count wraps to zero after one full word of slips.

Top module: `bitslip_aligner`

## Requirements
- R1: Each detected rising edge of the slip request, with the alignment mode enabled, increments `slip_count` by exactly one.
- R2: With offset k equal to `slip_count`, the output word is bits k to k+W-1 of the 2W-bit pair formed by the previous input word in the low half and the current input word in the high half. Bit 0 is the earliest received bit.
- R3: The slip request passes through a two-flop synchronizer and an edge detector. When the clock edge that first samples a new high level on the request is edge e, `slip_count` takes its new value at edge e+2.
- R4: `slip_count` is 5 bits wide with the default parameters. It resets to 0 and stays in the range 0 to W-1.
- R5: A request held high causes exactly one slip. A further slip needs the line to go low and then high again.
- R6: A slip taken while `slip_count` is W-1 sets it to 0. This returns the boundary to offset zero, which is the same alignment one word later.
- R7: While `slip_mode_en` is low, rising edges on the request leave `slip_count` and the output word offset unchanged. A request that is already high when the mode is enabled causes no slip.
- R8: A synchronous reset clears `slip_count`, the held previous word, the output word and the synchronizer and edge-detector state.
- R9: The output word is registered once. The word registered at edge t is built from the input sampled at t, the input sampled at t-1, and the count held before t. A new offset therefore first appears in the word registered at the edge after the count changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered receive clock |
| rst | input | 1 | Synchronous active-high reset |
| slip_mode_en | input | 1 | Enables acting on slip requests |
| slip_req_async | input | 1 | Asynchronous, edge-sensitive slip request |
| rx_word | input | DATA_W | Parallel word from the deserializer, bit 0 earliest |
| aligned_word | output | DATA_W | Registered word at the current boundary |
| slip_count | output | CNT_W | Bits slipped so far (0 to DATA_W-1) |

## Verification
The hardest case to reach is the boundary between a held request and the mode input. The request is raised and held while the mode is off, then the mode is turned on while the line stays high, and no slip may follow. The stimulus sets up this case on purpose and keeps the line high across the mode change. Reaching the wrap needs a full word's worth of separated request pulses, so a run of short pulses is driven to carry the count past W-1. A reset is then applied while the count is non-zero.

// File: rtl/bsa_pkg.sv
package bsa_pkg;
   typedef enum int {
      BSA_SEL_INDEXED = 0,
      BSA_SEL_LOG     = 1
   } bsa_sel_e;

   localparam int BSA_MIN_SYNC = 2;
endpackage

// File: rtl/bsa_slip_detect.sv
module bsa_slip_detect #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic mode_en,
   input  logic req_async,
   output logic slip_pulse
);
   import bsa_pkg::*;

   initial begin : param_check
      assert (SYNC_STAGES >= BSA_MIN_SYNC)
         else $fatal(1, "SYNC_STAGES below minimum");
   end

   logic sync_q [SYNC_STAGES];
   logic seen_q;

   for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (rst) sync_q[0] <= 1'b0;
            else     sync_q[0] <= req_async;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (rst) sync_q[i] <= 1'b0;
            else     sync_q[i] <= sync_q[i-1];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) seen_q <= 1'b0;
      else     seen_q <= sync_q[SYNC_STAGES-1];
   end

   assign slip_pulse = mode_en & sync_q[SYNC_STAGES-1] & ~seen_q;

   assert_single_pulse_R5: assert property (@(posedge clk) disable iff (rst)
      slip_pulse |=> !slip_pulse);
endmodule

// File: rtl/bsa_slip_counter.sv
module bsa_slip_counter #(
   parameter int CNT_W = 5,
   parameter int LIMIT = 9
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             adv,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] TOP = CNT_W'(LIMIT);

   initial begin : param_check
      assert (LIMIT >= 1 && LIMIT < (1 << CNT_W))
         else $fatal(1, "LIMIT does not fit CNT_W");
   end

   always_ff @(posedge clk) begin
      if (rst)           count <= '0;
      else if (adv) begin
         if (count == TOP) count <= '0;
         else              count <= count + 1'b1;
      end
   end

   assert_advance_R1: assert property (@(posedge clk) disable iff (rst)
      (adv && count != TOP) |=> count == $past(count) + 1'b1);
   assert_wrap_R6: assert property (@(posedge clk) disable iff (rst)
      (adv && count == TOP) |=> count == '0);
   assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
      !adv |=> $stable(count));
   assert_range_R4: assert property (@(posedge clk) disable iff (rst)
      count <= TOP);
endmodule

// File: rtl/bsa_window_select.sv
module bsa_window_select
   import bsa_pkg::*;
#(
   parameter int       DATA_W = 10,
   parameter int       OFF_W  = 4,
   parameter bsa_sel_e STYLE  = BSA_SEL_LOG
) (
   input  logic [2*DATA_W-1:0] pair,
   input  logic [OFF_W-1:0]    offset,
   output logic [DATA_W-1:0]   word
);
   if (STYLE == BSA_SEL_INDEXED) begin : g_indexed
      assign word = pair[offset +: DATA_W];
   end else begin : g_log
      logic [2*DATA_W-1:0] stg [OFF_W+1];
      assign stg[0] = pair;
      for (genvar s = 0; s < OFF_W; s++) begin : g_step
         localparam int SH = 1 << s;
         assign stg[s+1] = offset[s] ? (stg[s] >> SH) : stg[s];
      end
      assign word = stg[OFF_W][DATA_W-1:0];
   end
endmodule

// File: rtl/bitslip_aligner.sv
module bitslip_aligner
   import bsa_pkg::*;
#(
   parameter int       DATA_W      = 10,
   parameter int       CNT_W       = 5,
   parameter int       SYNC_STAGES = 2,
   parameter bsa_sel_e SEL_STYLE   = BSA_SEL_LOG
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              slip_mode_en,
   input  logic              slip_req_async,
   input  logic [DATA_W-1:0] rx_word,
   output logic [DATA_W-1:0] aligned_word,
   output logic [CNT_W-1:0]  slip_count
);
   localparam int OFF_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;

   initial begin : param_check
      assert (DATA_W >= 2) else $fatal(1, "DATA_W must be at least 2");
      assert (CNT_W >= OFF_W) else $fatal(1, "CNT_W too narrow for DATA_W");
   end

   logic                slip_pulse;
   logic [DATA_W-1:0]   prev_q;
   logic [DATA_W-1:0]   sel_word;
   logic [OFF_W-1:0]    offset;

   bsa_slip_detect #(.SYNC_STAGES(SYNC_STAGES)) u_detect (
      .clk(clk), .rst(rst), .mode_en(slip_mode_en),
      .req_async(slip_req_async), .slip_pulse(slip_pulse));

   bsa_slip_counter #(.CNT_W(CNT_W), .LIMIT(DATA_W-1)) u_count (
      .clk(clk), .rst(rst), .adv(slip_pulse), .count(slip_count));

   assign offset = OFF_W'(slip_count);

   bsa_window_select #(.DATA_W(DATA_W), .OFF_W(OFF_W), .STYLE(SEL_STYLE)) u_sel (
      .pair({rx_word, prev_q}), .offset(offset), .word(sel_word));

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_q       <= '0;
         aligned_word <= '0;
      end else begin
         prev_q       <= rx_word;
         aligned_word <= sel_word;
      end
   end

   assert_mode_off_R7: assert property (@(posedge clk) disable iff (rst)
      !slip_mode_en |=> $stable(slip_count));
   assert_zero_offset_R2: assert property (@(posedge clk) disable iff (rst)
      (slip_count == '0) |=> aligned_word == $past(prev_q));
   assert_full_offset_R9: assert property (@(posedge clk) disable iff (rst)
      (slip_count == CNT_W'(DATA_W-1)) |=>
      aligned_word[0] == $past(prev_q[DATA_W-1]));
endmodule

// File: tb/sim_bitslip_aligner.sv
`timescale 1ns/1ps
module sim_bitslip_aligner;
   localparam int W  = 10;
   localparam int CW = 5;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          mode = 1'b0;
   logic          slip = 1'b0;
   logic [W-1:0]  din = '0;
   logic [W-1:0]  dout;
   logic [CW-1:0] cnt;

   always #2.5 clk = ~clk;

   bitslip_aligner #(.DATA_W(W), .CNT_W(CW)) u0 (
      .clk(clk), .rst(rst), .slip_mode_en(mode), .slip_req_async(slip),
      .rx_word(din), .aligned_word(dout), .slip_count(cnt));

   typedef struct {
      logic [W-1:0]  word;
      logic [CW-1:0] count;
      string         tag;
   } exp_t;

   exp_t exp_q [$];
   int   n_checks = 0;
   int   n_fail = 0;
   bit   done = 1'b0;

   logic [W-1:0]  m_prev = '0;
   logic [CW-1:0] m_cnt = '0;
   logic          last_s = 1'b0;
   logic          p1 = 1'b0;
   logic          p2 = 1'b0;

   function automatic logic [W-1:0] window(logic [W-1:0] cur, logic [W-1:0] prv, int k);
      logic [W-1:0] r;
      for (int i = 0; i < W; i++)
         r[i] = (k + i < W) ? prv[k+i] : cur[k+i-W];
      return r;
   endfunction

   task automatic step(input logic [W-1:0] d, input logic s, input logic m,
                       input logic r, input string tag);
      exp_t e;
      logic [CW-1:0] nc;
      @(negedge clk);
      din = d; slip = s; mode = m; rst = r;
      e.tag = tag;
      if (r) begin
         e.word = '0; e.count = '0;
         m_prev = '0; m_cnt = '0; p1 = 1'b0; p2 = 1'b0; last_s = 1'b0;
      end else begin
         e.word = window(d, m_prev, int'(m_cnt));
         nc = m_cnt;
         if (p1) nc = (m_cnt == CW'(W-1)) ? '0 : m_cnt + 1'b1;
         e.count = nc;
         p1 = p2;
         p2 = s & ~last_s & m;
         last_s = s;
         m_prev = d;
         m_cnt = nc;
      end
      exp_q.push_back(e);
   endtask

   always @(posedge clk) begin
      #1;
      if (exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         n_checks += 2;
         if (dout !== e.word) begin
            n_fail++;
            $display("FAIL %s aligned_word got %h expected %h", e.tag, dout, e.word);
         end
         if (cnt !== e.count) begin
            n_fail++;
            $display("FAIL %s slip_count got %0d expected %0d", e.tag, cnt, e.count);
         end
      end
   end

   initial begin
      #200000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      // R8: reset state
      repeat (3) step(W'($urandom), 1'b0, 1'b0, 1'b1, "R8");
      // R2 / R9: offset zero with random and walking data
      for (int i = 0; i < 6; i++) step(W'($urandom), 1'b0, 1'b1, 1'b0, "R9");
      for (int i = 0; i < W; i++) step(W'(1) << i, 1'b0, 1'b1, 1'b0, "R2");
      // R3 / R5: one request held high for many cycles gives one slip
      for (int i = 0; i < 12; i++) step(W'($urandom), 1'b1, 1'b1, 1'b0, "R5");
      for (int i = 0; i < 4; i++) step(W'($urandom), 1'b0, 1'b1, 1'b0, "R3");
      // R1 / R6: short pulses carry the count through a full word and wrap
      for (int j = 0; j < W + 2; j++) begin
         step(W'($urandom), 1'b1, 1'b1, 1'b0, "R1");
         for (int i = 0; i < 3; i++) step(W'($urandom), 1'b0, 1'b1, 1'b0, "R6");
      end
      for (int i = 0; i < 4; i++) step(10'h2AA, 1'b0, 1'b1, 1'b0, "R2");
      // R7: edges while mode is off are ignored
      for (int j = 0; j < 3; j++) begin
         step(W'($urandom), 1'b1, 1'b0, 1'b0, "R7");
         for (int i = 0; i < 3; i++) step(W'($urandom), 1'b0, 1'b0, 1'b0, "R7");
      end
      // R7: request already high when mode is enabled
      for (int i = 0; i < 6; i++) step(W'($urandom), 1'b1, 1'b0, 1'b0, "R7");
      for (int i = 0; i < 6; i++) step(W'($urandom), 1'b1, 1'b1, 1'b0, "R7");
      for (int i = 0; i < 4; i++) step(W'($urandom), 1'b0, 1'b1, 1'b0, "R7");
      // R4: more slips, then reset with a non-zero count
      for (int j = 0; j < 3; j++) begin
         step(W'($urandom), 1'b1, 1'b1, 1'b0, "R4");
         for (int i = 0; i < 3; i++) step(W'($urandom), 1'b0, 1'b1, 1'b0, "R4");
      end
      for (int i = 0; i < 2; i++) step(W'($urandom), 1'b0, 1'b1, 1'b1, "R8");
      for (int i = 0; i < 5; i++) step(W'($urandom), 1'b0, 1'b1, 1'b0, "R8");
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule